// File: doc/BRIEF.md
# Link Self-Test Pass Monitor

This block sits on the receive side of a high-speed serial link and checks the link while a built-in self-test runs. During the test the far end sends frames whose checked payload should decode to all zeros. The monitor compares each received frame against that pattern and counts the frames that hold any wrong bit. It drives a single PASS output that carries two kinds of information. While the test runs, PASS is high and drops for half a clock period for each bad frame, so outside logic can count errors. After the test ends, PASS holds a verdict: high if no error was seen, low if any was.

A test runs for as long as either of two enables is high: an external pin or a configuration register bit. Checking needs link lock. While lock is missing, frames are ignored and PASS keeps its value. A saturating counter of errored frames can be read at any time. A new test, reset or power-down clears the held verdict. A separate output combines a pin and a register bit that choose the internal oscillator as the test clock source instead of the pixel clock.

Top module: `lbist_pass_mon`

## Requirements
- R1: The test is active in every cycle in which `en_pin_i` or `en_reg_i` is high. If one enable drops while the other stays high, the test keeps running.
- R2: At the first clock edge that samples the test active, PASS goes high if `lock_i` is high. From then on, PASS stays high outside error pulses in every cycle in which the test is active and locked.
- R3: A frame is errored when any bit from position CHK_LO to CHK_HI (inclusive) is 1. The bits outside that range have no effect. Frames are checked only when `frame_vld_i` is high, the test is active, the previous cycle was also active, and lock is high. Frames that arrive while the test is inactive change neither PASS nor the counter.
- R4: For an errored frame sampled at clock edge k, `pass_o` is low during the high phase that follows edge k+1. It is high during the low phase of that same cycle, and it has no other low pulse.
- R5: At the first edge that samples the test inactive after it was active, PASS takes its final value. It is 1 if no frame was errored since the test started and 0 otherwise. PASS then stays constant in both clock phases.
- R6: The held verdict remains until one of three things happens. A new test start reloads PASS from `lock_i`. Active-low `rst_ni` sets PASS to 0. A high on the synchronous `pdown_i` at a clock edge sets PASS to 0 and clears the counter.
- R7: The rising edge of the combined enable clears the error history and the counter to 0 before checking resumes.
- R8: `err_cnt_o` rises by one for each errored frame and stops at 2^CNT_W-1. While the test is inactive it does not change.
- R9: While the test is active and `lock_i` is low, frames are ignored. PASS holds its current value and the counter does not change.
- R10: `osc_sel_o` is the OR of `osc_pin_i` and `osc_reg_i`. A value of 1 selects the internal oscillator.
- R11: During and just after reset, `pass_o` is 0 and `err_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock; PASS pulses use its high phase |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pdown_i | input | 1 | Synchronous power-down clear |
| en_pin_i | input | 1 | Test enable from pin |
| en_reg_i | input | 1 | Test enable from register bit |
| osc_pin_i | input | 1 | Oscillator select from pin |
| osc_reg_i | input | 1 | Oscillator select from register bit |
| lock_i | input | 1 | Link lock indication |
| frame_vld_i | input | 1 | Received frame valid this cycle |
| frame_i | input | FRAME_W | Received frame payload |
| pass_o | output | 1 | Live error strobe / held verdict |
| err_cnt_o | output | CNT_W | Saturating errored-frame count |
| osc_sel_o | output | 1 | 1 selects internal oscillator |

## Verification
The bench builds the block with FRAME_W=8, CHK_LO=1, CHK_HI=5 and CNT_W=4. With an 8-bit frame the bench can send every possible frame value and check the pulse for each one against a checked-range mask that it computes itself. This shows that the bits outside the range are ignored. The 4-bit counter reaches saturation within one sweep. Shorter runs then cover these cases: counting below saturation, lock loss partway through a test, overlap of the two enables, verdict hold, and clearing by a new start, power-down and reset.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic chk;
  } lbm_ctl_t;
endpackage

// File: rtl/lbm_frame_chk.sv
module lbm_frame_chk #(
  parameter int FRAME_W = 40,
  parameter int CHK_LO  = 1,
  parameter int CHK_HI  = 35
) (
  input  logic [FRAME_W-1:0] frame_i,
  output logic               bad_o
);
  logic [FRAME_W-1:0] mask;

  for (genvar i = 0; i < FRAME_W; i++) begin : g_mask
    if (i >= CHK_LO && i <= CHK_HI) begin : g_on
      assign mask[i] = 1'b1;
    end else begin : g_off
      assign mask[i] = 1'b0;
    end
  end

  // expected payload is all zeros: any set bit in range is an error
  assign bad_o = |(frame_i & mask);
endmodule

// File: rtl/lbm_sat_cnt.sv
module lbm_sat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (inc_i && cnt_o != CntMax) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/lbm_pulse_gen.sv
module lbm_pulse_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic err_i,
  input  logic lvl_i,
  output logic pass_o
);
  logic err_n;

  // retime on falling edge so the gate input only moves while clk is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_n <= 1'b0;
    end else if (clr_i) begin
      err_n <= 1'b0;
    end else begin
      err_n <= err_i;
    end
  end

  assign pass_o = lvl_i & ~(err_n & clk_i);
endmodule

// File: rtl/lbist_pass_mon.sv
module lbist_pass_mon
  import lbm_pkg::*;
#(
  parameter int FRAME_W = 40,
  parameter int CHK_LO  = 1,
  parameter int CHK_HI  = 35,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pdown_i,
  input  logic               en_pin_i,
  input  logic               en_reg_i,
  input  logic               osc_pin_i,
  input  logic               osc_reg_i,
  input  logic               lock_i,
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               pass_o,
  output logic [CNT_W-1:0]   err_cnt_o,
  output logic               osc_sel_o
);
  logic     act;
  logic     en_q;
  logic     pass_q;
  logic     sticky_q;
  logic     err_q;
  logic     bad;
  logic     hit;
  lbm_ctl_t ctl;

  assign act       = en_pin_i | en_reg_i;
  assign ctl.start = act & ~en_q;
  assign ctl.stop  = ~act & en_q;
  assign ctl.chk   = act & en_q & lock_i & frame_vld_i;
  assign hit       = ctl.chk & bad;
  assign osc_sel_o = osc_pin_i | osc_reg_i;

  lbm_frame_chk #(
    .FRAME_W(FRAME_W),
    .CHK_LO (CHK_LO),
    .CHK_HI (CHK_HI)
  ) i_fchk (
    .frame_i(frame_i),
    .bad_o  (bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      pass_q   <= 1'b0;
      sticky_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (pdown_i) begin
      en_q     <= 1'b0;
      pass_q   <= 1'b0;
      sticky_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      en_q  <= act;
      err_q <= hit;
      if (ctl.start) begin
        sticky_q <= 1'b0;
        pass_q   <= lock_i;
      end else if (act) begin
        if (lock_i) pass_q <= 1'b1;
        if (hit) sticky_q <= 1'b1;
      end else if (ctl.stop) begin
        pass_q <= ~sticky_q;
      end
    end
  end

  lbm_sat_cnt #(
    .CNT_W(CNT_W)
  ) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ctl.start | pdown_i),
    .inc_i (hit),
    .cnt_o (err_cnt_o)
  );

  lbm_pulse_gen i_pgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (pdown_i),
    .err_i (err_q),
    .lvl_i (pass_q),
    .pass_o(pass_o)
  );
endmodule

// File: rtl/lbist_pass_mon_chk.sv
module lbist_pass_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pdown_i,
  input logic             act_i,
  input logic             en_q_i,
  input logic             lock_i,
  input logic             pass_q_i,
  input logic             err_q_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  a_r8_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || pdown_i)
    (cnt_i == CntMax) |=> (cnt_i == CntMax || cnt_i == '0));

  a_r8_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_ni || pdown_i)
    act_i |=> (cnt_i >= $past(cnt_i) || cnt_i == '0));

  a_r8_frozen_idle: assert property (@(posedge clk_i) disable iff (!rst_ni || pdown_i)
    !act_i |=> $stable(cnt_i));

  a_r5_verdict_held: assert property (@(posedge clk_i) disable iff (!rst_ni || pdown_i)
    (!act_i && !en_q_i) |=> $stable(pass_q_i));

  a_r9_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || pdown_i)
    (act_i && en_q_i && !lock_i) |=> $stable(pass_q_i));

  a_r9_no_err_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni || pdown_i)
    !lock_i |=> !err_q_i);

  a_r2_high_running: assert property (@(posedge clk_i) disable iff (!rst_ni || pdown_i)
    (act_i && lock_i) |=> pass_q_i);
endmodule

bind lbist_pass_mon lbist_pass_mon_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pdown_i (pdown_i),
  .act_i   (act),
  .en_q_i  (en_q),
  .lock_i  (lock_i),
  .pass_q_i(pass_q),
  .err_q_i (err_q),
  .cnt_i   (err_cnt_o)
);

// File: tb/test_lbist_pass_mon.sv
module test_lbist_pass_mon;
  localparam int FW = 8;
  localparam int LO = 1;
  localparam int HI = 5;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pdown_i = 1'b0;
  logic          en_pin_i = 1'b0;
  logic          en_reg_i = 1'b0;
  logic          osc_pin_i = 1'b0;
  logic          osc_reg_i = 1'b0;
  logic          lock_i = 1'b0;
  logic          frame_vld_i = 1'b0;
  logic [FW-1:0] frame_i = '0;
  logic          pass_o;
  logic [CW-1:0] err_cnt_o;
  logic          osc_sel_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lbist_pass_mon #(.FRAME_W(FW), .CHK_LO(LO), .CHK_HI(HI), .CNT_W(CW)) i_lbist_pass_mon (
    .clk_i(clk), .rst_ni(rst_ni), .pdown_i(pdown_i), .en_pin_i(en_pin_i),
    .en_reg_i(en_reg_i), .osc_pin_i(osc_pin_i), .osc_reg_i(osc_reg_i),
    .lock_i(lock_i), .frame_vld_i(frame_vld_i), .frame_i(frame_i),
    .pass_o(pass_o), .err_cnt_o(err_cnt_o), .osc_sel_o(osc_sel_o)
  );

  task automatic chk(input string tag, input int actual, input int expected);
    n_chk++;
    if (actual !== expected) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, actual, expected, $time);
    end
  endtask

  function automatic bit is_bad(input int v);
    return ((v >> LO) & ((1 << (HI - LO + 1)) - 1)) != 0;
  endfunction

  // move to posedge + 1 ns (mid high phase)
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // send one frame, check PASS in high and low phase of the cycle after capture
  task automatic send(input int v, input int exp_hi, input int exp_lo, input string tag);
    frame_i = v[FW-1:0];
    frame_vld_i = 1'b1;
    tick();
    frame_vld_i = 1'b0;
    frame_i = '0;
    tick();
    chk({tag, " hi"}, int'(pass_o), exp_hi);
    #2;
    chk({tag, " lo"}, int'(pass_o), exp_lo);
  endtask

  initial begin
    int nbad;
    #5;
    chk("R11 pass in reset", int'(pass_o), 0);
    chk("R11 cnt in reset", int'(err_cnt_o), 0);
    tick();
    rst_ni = 1'b1;
    tick();
    chk("R11 pass after reset", int'(pass_o), 0);

    for (int s = 0; s < 4; s++) begin
      osc_pin_i = s[0];
      osc_reg_i = s[1];
      #1;
      chk("R10 osc select", int'(osc_sel_o), int'(s != 0));
    end

    // sweep every frame value
    en_pin_i = 1'b1;
    lock_i = 1'b1;
    tick();
    chk("R2 pass high on start", int'(pass_o), 1);
    chk("R7 cnt zero on start", int'(err_cnt_o), 0);
    nbad = 0;
    for (int v = 0; v < (1 << FW); v++) begin
      send(v, is_bad(v) ? 0 : 1, 1, "R3/R4 sweep pulse");
      if (is_bad(v)) nbad++;
    end
    chk("R8 saturated count", int'(err_cnt_o), (nbad > CMAX) ? CMAX : nbad);
    en_pin_i = 1'b0;
    tick();
    chk("R5 verdict fail hi", int'(pass_o), 0);
    #2;
    chk("R5 verdict fail lo", int'(pass_o), 0);
    frame_i = '1;
    frame_vld_i = 1'b1;
    repeat (3) tick();
    frame_vld_i = 1'b0;
    chk("R3 inactive frames ignored pass", int'(pass_o), 0);
    chk("R8 count frozen inactive", int'(err_cnt_o), CMAX);

    // register enable, lock late, partial count, lock loss
    lock_i = 1'b0;
    en_reg_i = 1'b1;
    tick();
    chk("R6 new test clears verdict", int'(pass_o), 0);
    chk("R7 count cleared", int'(err_cnt_o), 0);
    send(8'h3E, 0, 0, "R9 unlocked before lock");
    chk("R9 count unlocked", int'(err_cnt_o), 0);
    lock_i = 1'b1;
    tick();
    chk("R2 pass high on lock", int'(pass_o), 1);
    send(8'h01, 1, 1, "R3 bit0 ignored");
    send(8'h40, 1, 1, "R3 bit6 ignored");
    send(8'hC1, 1, 1, "R3 outside mix ignored");
    chk("R3 count no errors", int'(err_cnt_o), 0);
    for (int b = LO; b <= HI; b++) send(1 << b, 0, 1, "R4 single bit pulse");
    chk("R8 partial count", int'(err_cnt_o), HI - LO + 1);
    lock_i = 1'b0;
    tick();
    chk("R9 pass held lock lost", int'(pass_o), 1);
    send(8'h3E, 1, 1, "R9 frame ignored lock lost");
    chk("R9 count held lock lost", int'(err_cnt_o), HI - LO + 1);
    lock_i = 1'b1;
    en_reg_i = 1'b0;
    tick();
    chk("R5 verdict after errors", int'(pass_o), 0);

    // overlapping enables
    en_pin_i = 1'b1;
    en_reg_i = 1'b1;
    tick();
    chk("R7 count cleared again", int'(err_cnt_o), 0);
    en_pin_i = 1'b0;
    tick();
    send(8'h04, 0, 1, "R1 still active on reg");
    chk("R1 counted", int'(err_cnt_o), 1);
    en_reg_i = 1'b0;
    tick();
    chk("R5 verdict overlap", int'(pass_o), 0);

    // clean run
    en_pin_i = 1'b1;
    tick();
    for (int i = 0; i < 6; i++) send(8'hC1 & ~i, 1, 1, "R2 clean frames");
    en_pin_i = 1'b0;
    tick();
    for (int i = 0; i < 5; i++) begin
      chk("R5 clean verdict hi", int'(pass_o), 1);
      #2;
      chk("R5 clean verdict lo", int'(pass_o), 1);
      tick();
    end
    pdown_i = 1'b1;
    tick();
    pdown_i = 1'b0;
    chk("R6 pdown clears pass", int'(pass_o), 0);

    // reset clears count
    en_pin_i = 1'b1;
    tick();
    send(8'h20, 0, 1, "R4 pulse before reset");
    en_pin_i = 1'b0;
    tick();
    chk("R8 count before reset", int'(err_cnt_o), 1);
    rst_ni = 1'b0;
    #1;
    chk("R6 reset clears count", int'(err_cnt_o), 0);
    chk("R6 reset clears pass", int'(pass_o), 0);
    tick();
    rst_ni = 1'b1;
    tick();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule